// File: doc/BRIEF.md
# Programmable Clock-Slip Glitch Filter

This block decides whether a raw feedback-slip indication from a PLL is a real fault or only a short glitch. The raw indication is first brought into the filter clock domain by a chain of synchronizer flops. When filtering is active, the synchronized indication must then stay high for a programmed number of consecutive filter-clock cycles before the block raises its qualified slip flag. When filtering is not active, the synchronized indication passes through unchanged. Every qualified slip also sets a sticky status bit, which holds until software clears it.

Software controls the filter through two fields. A 6-bit minimum width sets the required slip length. A 4-bit enable code turns filtering on or off. Only privileged writes can change these fields, and both can be read back at any time. Filtering is active only when the enable code is an enabling value and the width is nonzero.

Top module: `slip_qualifier`

## Requirements
- R1: After reset, slip_flag and slip_sticky are 0, cfg_rd_count reads 0 and cfg_rd_key reads 4'h5.
- R2: With the reset settings (key 4'h5), a raw slip pulse passes through unfiltered: a pulse rising before posedge 1 shows on slip_flag after posedge 3 (two synchronizer flops plus one output flop), even if it is only one cycle wide.
- R3: A configuration write with cfg_priv low is ignored: both read-back fields keep their previous values.
- R4: A configuration write with cfg_wr and cfg_priv both high loads cfg_wdata_count and cfg_wdata_key, and both read back on the next cycle.
- R5: With filtering active and width N, a raw pulse of N cycles is recognized, and slip_flag rises after posedge N+2 counted from the pulse start. A pulse of N-1 cycles never raises slip_flag.
- R6: With width 1 and an enabling key, every slip is recognized, including a one-cycle pulse, with the same latency as pass-through.
- R7: Width 0 disables filtering even with an enabling key (4'hA), so the raw slip passes through.
- R8: Key value 4'hF is handled like the disabled state, so the raw slip passes through.
- R9: The largest width, 63, recognizes a 63-cycle pulse and rejects a 62-cycle pulse.
- R10: slip_sticky is set one cycle after slip_flag is high and stays set after the slip ends. A pulse on sts_clr clears it.
- R11: If the synchronized slip drops before the width is reached, the counter restarts. Two 3-cycle pulses separated by a one-cycle gap are not recognized at width 4.
- R12: When a set and a clear of slip_sticky happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slip_raw | input | 1 | Raw feedback-slip indication, asynchronous |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | High when the write is privileged |
| cfg_wdata_count | input | 6 | New minimum slip width |
| cfg_wdata_key | input | 4 | New filter enable code |
| sts_clr | input | 1 | Write-1 pulse that clears the sticky bit |
| cfg_rd_count | output | 6 | Current minimum slip width |
| cfg_rd_key | output | 4 | Current enable code |
| slip_flag | output | 1 | Qualified slip |
| slip_sticky | output | 1 | Sticky slip status |

## Verification
If the down counter holds a wrong value, the rise of slip_flag moves away from posedge N+2 of a pulse, or a pulse one cycle short of the width gets through. So a pulse swept at the threshold exposes the fault within N+3 cycles. A wrong enable decode shows within three cycles, because a one-cycle pulse either appears on slip_flag or does not. A fault in the sticky logic shows one cycle after a flag, or one cycle after a clear.

// File: rtl/slipq_pkg.sv
package slipq_pkg;
  localparam int CNT_W = 6;
  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_OFF = 4'h5;
  localparam logic [KEY_W-1:0] KEY_BAD = 4'hF;

  // filtering is live only for an enabling key and a nonzero width
  function automatic logic filter_on(input logic [KEY_W-1:0] key,
                                     input logic [CNT_W-1:0] width);
    return (key != KEY_OFF) && (key != KEY_BAD) && (width != '0);
  endfunction

  // width reached once at most one cycle of the count is left
  function automatic logic width_met(input logic [CNT_W-1:0] left);
    return left <= CNT_W'(1);
  endfunction
endpackage

// File: rtl/slipq_sync.sv
module slipq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/slipq_cfg.sv
module slipq_cfg
  import slipq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             priv,
  input  logic [CNT_W-1:0] wdata_count,
  input  logic [KEY_W-1:0] wdata_key,
  output logic [CNT_W-1:0] count_q,
  output logic [KEY_W-1:0] key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      key_q   <= KEY_OFF;
    end else if (wr && priv) begin
      count_q <= wdata_count;
      key_q   <= wdata_key;
    end
  end
endmodule

// File: rtl/slipq_counter.sv
module slipq_counter
  import slipq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_slip,
  input  logic             active,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] left,
  output logic             hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else if (!sync_slip || !active) left <= load_val;
    else if (left != '0) left <= left - CNT_W'(1);
  end

  assign hit = sync_slip && width_met(left);
endmodule

// File: rtl/slip_qualifier.sv
module slip_qualifier
  import slipq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slip_raw,
  input  logic             cfg_wr,
  input  logic             cfg_priv,
  input  logic [CNT_W-1:0] cfg_wdata_count,
  input  logic [KEY_W-1:0] cfg_wdata_key,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] cfg_rd_count,
  output logic [KEY_W-1:0] cfg_rd_key,
  output logic             slip_flag,
  output logic             slip_sticky
);
  logic             sync_slip;
  logic             filt_active;
  logic             qual_hit;
  logic [CNT_W-1:0] cnt_left;

  slipq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(slip_raw), .q(sync_slip)
  );

  slipq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .priv(cfg_priv),
    .wdata_count(cfg_wdata_count), .wdata_key(cfg_wdata_key),
    .count_q(cfg_rd_count), .key_q(cfg_rd_key)
  );

  assign filt_active = filter_on(cfg_rd_key, cfg_rd_count);

  slipq_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .sync_slip(sync_slip), .active(filt_active),
    .load_val(cfg_rd_count), .left(cnt_left), .hit(qual_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slip_flag   <= 1'b0;
      slip_sticky <= 1'b0;
    end else begin
      slip_flag   <= filt_active ? qual_hit : sync_slip;
      slip_sticky <= slip_flag | (slip_sticky & ~sts_clr);
    end
  end
endmodule

// File: rtl/slip_qualifier_chk.sv
module slip_qualifier_chk
  import slipq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             cfg_priv,
  input logic             sts_clr,
  input logic [CNT_W-1:0] cfg_rd_count,
  input logic [KEY_W-1:0] cfg_rd_key,
  input logic             slip_flag,
  input logic             slip_sticky,
  input logic             sync_slip,
  input logic             filt_active
);
  // R3
  unpriv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_priv) |=> ($stable(cfg_rd_count) && $stable(cfg_rd_key)));

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_active |=> (slip_flag == $past(sync_slip)));

  // R5
  no_early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_active && cfg_rd_count > CNT_W'(1) && $rose(sync_slip)) |=> !slip_flag);

  // R11
  drop_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_active && !sync_slip) |=> !slip_flag);

  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slip_flag |=> slip_sticky);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_sticky && !sts_clr) |=> slip_sticky);
endmodule

bind slip_qualifier slip_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
  .sts_clr(sts_clr), .cfg_rd_count(cfg_rd_count), .cfg_rd_key(cfg_rd_key),
  .slip_flag(slip_flag), .slip_sticky(slip_sticky),
  .sync_slip(sync_slip), .filt_active(filt_active)
);

// File: tb/tb_slip_qualifier.sv
`timescale 1ns/1ps
module tb_slip_qualifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slip_raw = 1'b0;
  logic       cfg_wr = 1'b0;
  logic       cfg_priv = 1'b0;
  logic [5:0] cfg_wdata_count = '0;
  logic [3:0] cfg_wdata_key = '0;
  logic       sts_clr = 1'b0;
  logic [5:0] cfg_rd_count;
  logic [3:0] cfg_rd_key;
  logic       slip_flag;
  logic       slip_sticky;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slip_qualifier dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit priv, input int cnt, input int key);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_priv = priv;
    cfg_wdata_count = 6'(cnt); cfg_wdata_key = 4'(key);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_priv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_sticky();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask

  // drive a pulse of w cycles; first = sample index of first flag high, -1 if none
  task automatic run_pulse(input int w, output int first);
    first = -1;
    @(negedge clk); slip_raw = 1'b1;
    for (int j = 1; j <= w + 10; j++) begin
      @(negedge clk);
      if (slip_flag && first < 0) first = j;
      if (j == w) slip_raw = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 flag", slip_flag, 0);
    check("R1 sticky", slip_sticky, 0);
    check("R1 count", cfg_rd_count, 0);
    check("R1 key", cfg_rd_key, 5);
  endtask

  task automatic t_bypass_default();
    int f;
    run_pulse(1, f);
    check("R2 bypass latency", f, 3);
  endtask

  task automatic t_priv();
    write_cfg(1'b0, 10, 4'hA);
    check("R3 count unchanged", cfg_rd_count, 0);
    check("R3 key unchanged", cfg_rd_key, 5);
    write_cfg(1'b1, 4, 4'hA);
    check("R4 count", cfg_rd_count, 4);
    check("R4 key", cfg_rd_key, 10);
  endtask

  task automatic t_width4();
    int f;
    run_pulse(3, f);
    check("R5 short pulse rejected", f, -1);
    run_pulse(4, f);
    check("R5 exact pulse latency", f, 6);
  endtask

  task automatic t_reload();
    int f = -1;
    @(negedge clk); slip_raw = 1'b1;
    for (int j = 1; j <= 18; j++) begin
      @(negedge clk);
      if (slip_flag && f < 0) f = j;
      if (j == 3) slip_raw = 1'b0;
      if (j == 4) slip_raw = 1'b1;
      if (j == 7) slip_raw = 1'b0;
    end
    check("R11 gap restarts count", f, -1);
  endtask

  task automatic t_width1();
    int f;
    write_cfg(1'b1, 1, 4'hA);
    run_pulse(1, f);
    check("R6 width1 latency", f, 3);
  endtask

  task automatic t_zero_count();
    int f;
    write_cfg(1'b1, 0, 4'hA);
    run_pulse(1, f);
    check("R7 zero count passes", f, 3);
  endtask

  task automatic t_bad_key();
    int f;
    write_cfg(1'b1, 4, 4'hF);
    run_pulse(1, f);
    check("R8 key F passes", f, 3);
  endtask

  task automatic t_width63();
    int f;
    write_cfg(1'b1, 63, 4'hA);
    run_pulse(62, f);
    check("R9 62 rejected", f, -1);
    run_pulse(63, f);
    check("R9 63 latency", f, 65);
  endtask

  task automatic t_sticky();
    int f;
    write_cfg(1'b1, 4, 4'hA);
    clear_sticky();
    @(negedge clk);
    check("R10 sticky cleared before", slip_sticky, 0);
    run_pulse(5, f);
    check("R10 flag low after pulse", slip_flag, 0);
    check("R10 sticky holds", slip_sticky, 1);
    clear_sticky();
    check("R10 sticky cleared", slip_sticky, 0);
  endtask

  task automatic t_priority();
    write_cfg(1'b1, 0, 4'h5);
    @(negedge clk); slip_raw = 1'b1;
    repeat (5) @(negedge clk);
    check("R12 flag high", slip_flag, 1);
    sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    check("R12 set beats clear", slip_sticky, 1);
    slip_raw = 1'b0;
    repeat (5) @(negedge clk);
    clear_sticky();
    check("R12 later clear", slip_sticky, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_bypass_default();
    t_priv();
    t_width4();
    t_reload();
    t_width1();
    t_zero_count();
    t_bad_key();
    t_width63();
    t_sticky();
    t_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule